// File: doc/BRIEF.md
# Serial Clock-Calendar Register Slave

This block is the slave end of a three-wire serial link to a clock-calendar register set. A host raises chip select while the serial clock is high, shifts in an eight-bit command, and then moves register bytes in or out one bit per serial-clock rising edge. The command names the direction (write or read) and a target: a one-byte control register, a seven-byte calendar set, or a three-byte time-of-day set. A dedicated command clears the control register. The calendar and time fields are plain storage. Nothing here advances them.

All three pins are sampled by the system clock `clk`. The block detects edges by comparing each pin with its value one clock earlier. The bidirectional data pin is split into an input, an output and an output enable. The pad ring joins them. A host may send the command in either bit order. When the received byte does not carry the command signature in its upper nibble, the block reverses all eight bits before it decodes them.

Top module: `rtc_serial_slave`

## Requirements
- R1: After `rst_n` is held low for one `clk` edge, `sio_oe` and `sio_o` are 0, the block is idle, and every register field reads back as zero.
- R2: A transfer starts only when `cs_i` rises while `sck_i` is high. If `cs_i` rises while `sck_i` is low, the block ignores all serial traffic until the next start.
- R3: Each serial byte is shifted least significant bit first, one bit per rising edge of `sck_i`, and a byte is complete after eight bits.
- R4: A command byte whose upper nibble is 0x6 is used as received. Any other command byte is bit-reversed (bit 0 swaps with bit 7, and so on) before decoding.
- R5: Decoded command bit 0 selects the direction: 0 is write and 1 is read. Bits 3:1 select the target: 0 is control clear, 1 is control, 2 is calendar and 3 is time. For example, 0x62/0x63 write/read control, 0x64/0x65 write/read calendar and 0x66/0x67 write/read time.
- R6: A control transfer carries 1 byte, a calendar transfer 7 bytes and a time transfer 3 bytes. After the last byte the block returns to idle, and any further bits before the next start have no effect.
- R7: Calendar bytes are ordered year, month, day, weekday, hour, minute, second. Time bytes are ordered hour, minute, second, and they share storage with the calendar hour, minute and second fields.
- R8: A control-clear command (target 0) sets the control register to zero. It leaves every calendar and time field unchanged and has no data phase.
- R9: When `cs_i` is low during a command or data phase, the transfer is aborted and the block returns to idle. A byte that is not complete is not committed. This also holds when `cs_i` falls in the same `clk` cycle as the `sck_i` rise that would complete the byte.
- R10: The stored field widths are year 8, month 5, day 6, weekday 3, hour 6, minute 7, second 7 and control 8 bits. Excess high bits are dropped on write and read back as zero.
- R11: On a read, each `sck_i` rise in the data phase places the next bit of the addressed byte on `sio_o`. `sio_oe` is high from the end of a read command until `cs_i` falls or `sck_i` rises once after the last bit. `sio_oe` is low during command input and write data.
- R12: A target selector of 4 to 7 returns the block to idle with no data phase. The data bits that follow change no register and do not raise `sio_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select from host, active high |
| sck_i | input | 1 | Serial clock from host |
| sio_i | input | 1 | Serial data from host |
| sio_o | output | 1 | Serial data to host during a read |
| sio_oe | output | 1 | Output enable for the serial data pad |

## Verification
An abort and a byte completion can land in the same `clk` cycle: the rise of `sck_i` that delivers the eighth data bit can arrive together with the fall of `cs_i`. The bench provokes this by changing both pins in a single drive step during a control write. It then reads the control register back through a normal read and checks that the aborted byte was never committed. A control-clear command issued between calendar writes and reads also checks that a clear and the untouched fields do not interfere.

// File: rtl/rtc_pkg.sv
// Package: shared types and helper functions for the serial clock-calendar slave.
// Assumes: command signature nibble 0x6; slot numbering 0..6 calendar order, 7 control.
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } xfer_state_t;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_CAL  = 2'd1,
        TGT_TOD  = 2'd2
    } target_t;

    localparam logic [3:0] CMD_SIGNATURE = 4'h6;
    localparam logic [2:0] SEL_CLEAR     = 3'd0;
    localparam logic [2:0] SEL_CTRL      = 3'd1;
    localparam logic [2:0] SEL_CAL       = 3'd2;
    localparam logic [2:0] SEL_TOD       = 3'd3;
    localparam logic [2:0] SLOT_CTRL     = 3'd7;
    localparam logic [2:0] SLOT_HOUR     = 3'd4;

    // Put the command into canonical bit order.
    function automatic logic [7:0] cmd_normalize(input logic [7:0] raw);
        logic [7:0] rev;
        for (int k = 0; k < 8; k++) rev[k] = raw[7-k];
        return (raw[7:4] == CMD_SIGNATURE) ? raw : rev;
    endfunction

    // Give the index of the last byte of a target's transfer.
    function automatic logic [2:0] last_byte(input target_t t);
        case (t)
            TGT_CAL: return 3'd6;
            TGT_TOD: return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    // Map a target and byte count to a storage slot.
    function automatic logic [2:0] slot_of(input target_t t, input logic [2:0] cnt);
        case (t)
            TGT_CAL: return cnt;
            TGT_TOD: return cnt + SLOT_HOUR;
            default: return SLOT_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/rtc_edge_track.sv
// Module: registers the chip-select and serial-clock pins and flags their rising edges.
// Assumes: pins are already synchronous to clk; the previous values reset high, so that
// a pin held high through reset does not give a false edge.
module rtc_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    output logic cs_rise,
    output logic sck_rise,
    output logic cs_prev
);
    logic sck_prev;

    // Hold one-cycle-old copies of the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b1;
        end else begin
            cs_prev  <= cs_i;
            sck_prev <= sck_i;
        end
    end

    // Flag rising edges by comparing each pin with its old copy.
    always_comb begin
        cs_rise  = cs_i & ~cs_prev;
        sck_rise = sck_i & ~sck_prev;
    end

endmodule

// File: rtl/rtc_shift_ctrl.sv
// Module: transfer sequencer. Collects the command, decodes it, counts bits and bytes,
// issues byte commits to the register file, and shifts read data out.
// Assumes: edge flags come from rtc_edge_track; read data for the addressed slot is
// available combinationally on rd_byte.
module rtc_shift_ctrl
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_i,
    input  logic        sio_i,
    input  logic        cs_rise,
    input  logic        cs_prev,
    input  logic        sck_i,
    input  logic        sck_rise,
    input  logic [7:0]  rd_byte,
    output logic [2:0]  slot,
    output logic        wr_en,
    output logic [7:0]  wr_byte,
    output logic        clr_ctrl,
    output logic        sio_o,
    output logic        sio_oe
);
    xfer_state_t st_q;
    target_t     tgt_q;
    logic [2:0]  bit_idx_q;
    logic [2:0]  byte_cnt_q;
    logic [7:0]  sh_buf_q;
    logic        oe_q;
    logic        sio_q;

    logic [7:0]  assembled;
    logic [7:0]  cmd_dec;
    logic        step;
    logic        byte_done;
    logic        last_q;

    // Merge the incoming bit into the partial byte and decode the command form.
    always_comb begin
        assembled            = sh_buf_q;
        assembled[bit_idx_q] = sio_i;
        cmd_dec              = cmd_normalize(assembled);
        step                 = cs_i & sck_rise;
        byte_done            = (bit_idx_q == 3'd7);
        last_q               = (byte_cnt_q == last_byte(tgt_q));
    end

    // Drive the register-file strobes for a byte commit or a control clear.
    always_comb begin
        slot     = slot_of(tgt_q, byte_cnt_q);
        wr_byte  = assembled;
        wr_en    = (st_q == ST_WR) && step && byte_done;
        clr_ctrl = (st_q == ST_CMD) && step && byte_done && (cmd_dec[3:1] == SEL_CLEAR);
    end

    // Sequence the transfer phases, counters and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            tgt_q      <= TGT_CTRL;
            bit_idx_q  <= '0;
            byte_cnt_q <= '0;
            sh_buf_q   <= '0;
            oe_q       <= 1'b0;
            sio_q      <= 1'b0;
        end else if (st_q != ST_IDLE && !cs_i) begin
            st_q       <= ST_IDLE;
            bit_idx_q  <= '0;
            byte_cnt_q <= '0;
            sh_buf_q   <= '0;
            oe_q       <= 1'b0;
            sio_q      <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!cs_i || sck_rise) begin
                        oe_q  <= 1'b0;
                        sio_q <= 1'b0;
                    end
                    if (cs_rise && sck_i) begin
                        st_q      <= ST_CMD;
                        bit_idx_q <= '0;
                        sh_buf_q  <= '0;
                    end
                end
                ST_CMD: begin
                    if (step) begin
                        if (byte_done) begin
                            bit_idx_q  <= '0;
                            sh_buf_q   <= '0;
                            byte_cnt_q <= '0;
                            case (cmd_dec[3:1])
                                SEL_CTRL: begin
                                    tgt_q <= TGT_CTRL;
                                    st_q  <= cmd_dec[0] ? ST_RD : ST_WR;
                                    oe_q  <= cmd_dec[0];
                                end
                                SEL_CAL: begin
                                    tgt_q <= TGT_CAL;
                                    st_q  <= cmd_dec[0] ? ST_RD : ST_WR;
                                    oe_q  <= cmd_dec[0];
                                end
                                SEL_TOD: begin
                                    tgt_q <= TGT_TOD;
                                    st_q  <= cmd_dec[0] ? ST_RD : ST_WR;
                                    oe_q  <= cmd_dec[0];
                                end
                                default: st_q <= ST_IDLE;
                            endcase
                        end else begin
                            sh_buf_q  <= assembled;
                            bit_idx_q <= bit_idx_q + 3'd1;
                        end
                    end
                end
                ST_WR, ST_RD: begin
                    if (step) begin
                        if (st_q == ST_RD) sio_q <= rd_byte[bit_idx_q];
                        if (byte_done) begin
                            bit_idx_q <= '0;
                            sh_buf_q  <= '0;
                            if (last_q) begin
                                byte_cnt_q <= '0;
                                st_q       <= ST_IDLE;
                            end else begin
                                byte_cnt_q <= byte_cnt_q + 3'd1;
                            end
                        end else begin
                            sh_buf_q  <= assembled;
                            bit_idx_q <= bit_idx_q + 3'd1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign sio_o  = sio_q;
    assign sio_oe = oe_q;

    // R9
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !cs_i) |=> (st_q == ST_IDLE));

    // R2
    cmd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMD && $past(st_q) == ST_IDLE) |-> ($past(cs_i) && !$past(cs_prev) && $past(sck_i)));

    // R11
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD) |-> sio_oe);

    // R11
    quiet_outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMD || st_q == ST_WR) |-> !sio_oe);

    // R6
    byte_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt_q <= 3'd6);

endmodule

// File: rtl/rtc_regfile.sv
// Module: calendar, time and control storage, with a byte-wide commit port and a read mux.
// Assumes: slots 0..6 are year, month, day, weekday, hour, minute, second and slot 7 is
// control; commit and clear never coincide.
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int YEAR_W = 8,
    parameter int MON_W  = 5,
    parameter int DAY_W  = 6,
    parameter int WDAY_W = 3,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEC_W  = 7,
    parameter int CTRL_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] slot,
    input  logic [7:0] wr_byte,
    input  logic       clr_ctrl,
    output logic [7:0] rd_byte
);
    logic [YEAR_W-1:0] year_q;
    logic [MON_W-1:0]  mon_q;
    logic [DAY_W-1:0]  day_q;
    logic [WDAY_W-1:0] wday_q;
    logic [HOUR_W-1:0] hour_q;
    logic [MIN_W-1:0]  min_q;
    logic [SEC_W-1:0]  sec_q;
    logic [CTRL_W-1:0] ctrl_q;

    // Commit a received byte to its field, or clear the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= '0;
            mon_q  <= '0;
            day_q  <= '0;
            wday_q <= '0;
            hour_q <= '0;
            min_q  <= '0;
            sec_q  <= '0;
            ctrl_q <= '0;
        end else if (clr_ctrl) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (slot)
                3'd0:    year_q <= wr_byte[YEAR_W-1:0];
                3'd1:    mon_q  <= wr_byte[MON_W-1:0];
                3'd2:    day_q  <= wr_byte[DAY_W-1:0];
                3'd3:    wday_q <= wr_byte[WDAY_W-1:0];
                3'd4:    hour_q <= wr_byte[HOUR_W-1:0];
                3'd5:    min_q  <= wr_byte[MIN_W-1:0];
                3'd6:    sec_q  <= wr_byte[SEC_W-1:0];
                default: ctrl_q <= wr_byte[CTRL_W-1:0];
            endcase
        end
    end

    // Select the addressed field, zero-extended to a byte.
    always_comb begin
        rd_byte = '0;
        case (slot)
            3'd0:    rd_byte[YEAR_W-1:0] = year_q;
            3'd1:    rd_byte[MON_W-1:0]  = mon_q;
            3'd2:    rd_byte[DAY_W-1:0]  = day_q;
            3'd3:    rd_byte[WDAY_W-1:0] = wday_q;
            3'd4:    rd_byte[HOUR_W-1:0] = hour_q;
            3'd5:    rd_byte[MIN_W-1:0]  = min_q;
            3'd6:    rd_byte[SEC_W-1:0]  = sec_q;
            default: rd_byte[CTRL_W-1:0] = ctrl_q;
        endcase
    end

    // R8
    clear_zeroes_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ctrl |=> (ctrl_q == '0));

    // R8
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(year_q) && $stable(mon_q) && $stable(day_q) && $stable(wday_q)
                    && $stable(hour_q) && $stable(min_q) && $stable(sec_q)));

endmodule

// File: rtl/rtc_serial_slave.sv
// Module: top of the serial clock-calendar slave. Joins the edge tracker, the transfer
// sequencer and the register file.
// Assumes: cs_i, sck_i and sio_i are synchronous to clk, and each serial level lasts
// at least one clk cycle.
module rtc_serial_slave #(
    parameter int YEAR_W = 8,
    parameter int MON_W  = 5,
    parameter int DAY_W  = 6,
    parameter int WDAY_W = 3,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEC_W  = 7,
    parameter int CTRL_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sio_i,
    output logic sio_o,
    output logic sio_oe
);
    logic       cs_rise;
    logic       sck_rise;
    logic       cs_prev;
    logic [2:0] slot;
    logic       wr_en;
    logic [7:0] wr_byte;
    logic       clr_ctrl;
    logic [7:0] rd_byte;

    rtc_edge_track u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .sck_i    (sck_i),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .cs_prev  (cs_prev)
    );

    rtc_shift_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .sio_i    (sio_i),
        .cs_rise  (cs_rise),
        .cs_prev  (cs_prev),
        .sck_i    (sck_i),
        .sck_rise (sck_rise),
        .rd_byte  (rd_byte),
        .slot     (slot),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .clr_ctrl (clr_ctrl),
        .sio_o    (sio_o),
        .sio_oe   (sio_oe)
    );

    rtc_regfile #(
        .YEAR_W (YEAR_W),
        .MON_W  (MON_W),
        .DAY_W  (DAY_W),
        .WDAY_W (WDAY_W),
        .HOUR_W (HOUR_W),
        .MIN_W  (MIN_W),
        .SEC_W  (SEC_W),
        .CTRL_W (CTRL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .slot     (slot),
        .wr_byte  (wr_byte),
        .clr_ctrl (clr_ctrl),
        .rd_byte  (rd_byte)
    );

endmodule

// File: tb/test_rtc_serial_slave.sv
// Scoreboard bench: read tasks push expected bytes, and a monitor compares the bytes
// that were shifted out.
module test_rtc_serial_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0;
    logic sck_i = 1'b1;
    logic sio_i = 1'b0;
    logic sio_o;
    logic sio_oe;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] act_q[$];

    always #2.5 clk = ~clk;

    rtc_serial_slave i_rtc_serial_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_i   (cs_i),
        .sck_i  (sck_i),
        .sio_i  (sio_i),
        .sio_o  (sio_o),
        .sio_oe (sio_oe)
    );

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: pop each produced byte and compare it with the oldest expectation.
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            logic [7:0] a;
            sb_item_t   e;
            a = act_q.pop_front();
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(a == e.val, e.tag, a, e.val);
            end else begin
                chk(1'b0, "scoreboard-unexpected", a, 8'h00);
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string tag);
        sb_item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic sck_bit(input logic b);
        @(negedge clk) begin sck_i = 1'b0; sio_i = b; end
        @(negedge clk) sck_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_xfer();
        @(negedge clk) begin sck_i = 1'b1; cs_i = 1'b1; end
        @(negedge clk);
    endtask

    task automatic end_xfer();
        @(negedge clk) cs_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) sck_bit(b[i]);
    endtask

    task automatic write_regs(input logic [7:0] cmd, input logic [7:0] d [], input int n);
        start_xfer();
        send_byte(cmd);
        for (int k = 0; k < n; k++) send_byte(d[k]);
        end_xfer();
    endtask

    task automatic read_regs(input logic [7:0] cmd, input int n, input string tag);
        logic [7:0] b;
        start_xfer();
        send_byte(cmd);
        chk(sio_oe == 1'b1, {tag, " R11 oe after read cmd"}, {7'd0, sio_oe}, 8'h01);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                sck_bit(1'b0);
                b[i] = sio_o;
            end
            act_q.push_back(b);
        end
        chk(sio_oe == 1'b1, {tag, " R11 oe held after last bit"}, {7'd0, sio_oe}, 8'h01);
        end_xfer();
        chk(sio_oe == 1'b0, {tag, " R11 oe off after cs low"}, {7'd0, sio_oe}, 8'h00);
    endtask

    initial begin
        logic [7:0] d [];
        d = new[7];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(sio_oe == 1'b0, "R1 oe at reset", {7'd0, sio_oe}, 8'h00);
        chk(sio_o == 1'b0, "R1 sio_o at reset", {7'd0, sio_o}, 8'h00);
        expect_byte(8'h00, "R1 control zero");
        read_regs(8'h63, 1, "R1");
        for (int k = 0; k < 7; k++) expect_byte(8'h00, "R1 calendar zero");
        read_regs(8'h65, 7, "R1");

        // R3 R5: write and read control in canonical order
        d[0] = 8'hA5;
        write_regs(8'h62, d, 1);
        expect_byte(8'hA5, "R3 R5 control write/read");
        read_regs(8'h63, 1, "R5");

        // R4: reversed commands (0x46 reverses to 0x62, 0xC6 to 0x63)
        d[0] = 8'h3C;
        write_regs(8'h46, d, 1);
        expect_byte(8'h3C, "R4 reversed command");
        read_regs(8'hC6, 1, "R4");

        // R7 R10: calendar write with over-wide values
        d[0] = 8'h99; d[1] = 8'hFF; d[2] = 8'hFF; d[3] = 8'hFD;
        d[4] = 8'hE3; d[5] = 8'hD9; d[6] = 8'hFF;
        write_regs(8'h64, d, 7);
        expect_byte(8'h99, "R7 year");
        expect_byte(8'h1F, "R10 month width");
        expect_byte(8'h3F, "R10 day width");
        expect_byte(8'h05, "R10 weekday width");
        expect_byte(8'h23, "R10 hour width");
        expect_byte(8'h59, "R10 minute width");
        expect_byte(8'h7F, "R10 second width");
        read_regs(8'h65, 7, "R7");

        // R7: time-only set shares the hour/minute/second fields
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        write_regs(8'h66, d, 3);
        expect_byte(8'h11, "R7 time hour");
        expect_byte(8'h22, "R7 time minute");
        expect_byte(8'h33, "R7 time second");
        read_regs(8'h67, 3, "R7");
        expect_byte(8'h99, "R7 cal year kept");
        expect_byte(8'h1F, "R7 cal month kept");
        expect_byte(8'h3F, "R7 cal day kept");
        expect_byte(8'h05, "R7 cal weekday kept");
        expect_byte(8'h11, "R7 cal hour shared");
        expect_byte(8'h22, "R7 cal minute shared");
        expect_byte(8'h33, "R7 cal second shared");
        read_regs(8'h65, 7, "R7");

        // R8: control clear keeps time fields
        start_xfer();
        send_byte(8'h60);
        chk(sio_oe == 1'b0, "R8 no data phase", {7'd0, sio_oe}, 8'h00);
        end_xfer();
        expect_byte(8'h00, "R8 control cleared");
        read_regs(8'h63, 1, "R8");
        expect_byte(8'h11, "R8 hour kept");
        expect_byte(8'h22, "R8 minute kept");
        expect_byte(8'h33, "R8 second kept");
        read_regs(8'h67, 3, "R8");

        // R6: extra bits after a one-byte control write are ignored
        start_xfer();
        send_byte(8'h62);
        send_byte(8'h5A);
        send_byte(8'hFF);
        chk(sio_oe == 1'b0, "R6 no drive after end", {7'd0, sio_oe}, 8'h00);
        end_xfer();
        expect_byte(8'h5A, "R6 only first byte kept");
        read_regs(8'h63, 1, "R6");

        // R9: abort after half a byte
        start_xfer();
        send_byte(8'h62);
        for (int i = 0; i < 4; i++) sck_bit(1'b1);
        end_xfer();
        expect_byte(8'h5A, "R9 partial byte dropped");
        read_regs(8'h63, 1, "R9");

        // R9: cs falls in the same cycle as the completing sck rise
        start_xfer();
        send_byte(8'h62);
        for (int i = 0; i < 7; i++) sck_bit(1'b1);
        @(negedge clk) begin sck_i = 1'b0; sio_i = 1'b1; end
        @(negedge clk) begin sck_i = 1'b1; cs_i = 1'b0; end
        @(negedge clk);
        @(negedge clk);
        expect_byte(8'h5A, "R9 same-cycle abort wins");
        read_regs(8'h63, 1, "R9");

        // R9: abort during read drops oe
        start_xfer();
        send_byte(8'h65);
        sck_bit(1'b0);
        end_xfer();
        chk(sio_oe == 1'b0, "R9 read abort oe", {7'd0, sio_oe}, 8'h00);

        // R2: cs rising with sck low starts nothing
        @(negedge clk) sck_i = 1'b0;
        @(negedge clk) cs_i = 1'b1;
        @(negedge clk);
        send_byte(8'h62);
        send_byte(8'hC3);
        end_xfer();
        expect_byte(8'h5A, "R2 no start with sck low");
        read_regs(8'h63, 1, "R2");

        // R12: unassigned selectors
        start_xfer();
        send_byte(8'h6E);
        send_byte(8'h00);
        end_xfer();
        start_xfer();
        send_byte(8'h6F);
        chk(sio_oe == 1'b0, "R12 read sel7 no oe", {7'd0, sio_oe}, 8'h00);
        sck_bit(1'b0);
        chk(sio_oe == 1'b0, "R12 still no oe", {7'd0, sio_oe}, 8'h00);
        end_xfer();
        expect_byte(8'h5A, "R12 control untouched");
        read_regs(8'h63, 1, "R12");
        expect_byte(8'h11, "R12 hour untouched");
        expect_byte(8'h22, "R12 minute untouched");
        expect_byte(8'h33, "R12 second untouched");
        read_regs(8'h67, 3, "R12");

        // R1: reset does not leave stale output
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        expect_byte(8'h00, "R1 control after reset");
        read_regs(8'h63, 1, "R1");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard-leftover", exp_q.size[7:0], 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule